// File: doc/BRIEF.md
# Atomic XOR Read-Modify-Write Unit

This block executes one atomic fetch-and-XOR memory instruction. It takes a 32-bit instruction word and checks it against a fixed bit layout. It reads the operand register and the base register through a combinational register-read port. It then performs a locked read, XOR and write sequence on a valid/ready memory port, and returns the value it loaded first on a destination-register write port.

The access is either a 32-bit word or a 64-bit doubleword. A base field of 31 selects the stack-pointer input, and that value must be aligned to 16 bytes. A destination field of 31 means the result is dropped. An operand field of 31 supplies a zero operand.

The unit handles one instruction at a time. A new instruction is accepted only while the unit is idle.

Top module: `atomic_xor_unit`

## Requirements
- R1: An instruction matches when its bits equal 1 at 31, 111 at 29:27, 0 at 26, 00 at 25:24, 00 at 23:22, 1 at 21, 0 at 15, 010 at 14:12 and 00 at 11:10. Bit 30 is free. A non-matching word that is accepted raises `illegal` for one cycle, leaves `busy` low, and causes no memory access and no writeback.
- R2: The operand register number is taken from bits 20:16, the base register number from bits 9:5 and the destination register number from bits 4:0. These are the values driven on `rdAddrA`, `rdAddrB` and `wbAddr`.
- R3: A matching instruction issues one read at the base address, then one write to the same address carrying the loaded value XOR the operand. It then writes the loaded value to the destination register.
- R4: Bit 30 = 1 selects a doubleword access: the XOR covers all 64 bits and `memWstrb` is 0xFF. Bit 30 = 0 selects a word access: the data sits in the low 32 bits of the bus, only the low 32 bits of the operand take part, and `memWstrb` is 0x0F.
- R5: For a word access the value written back is zero-extended, so `wbData[63:32]` is 0.
- R6: A base field of 31 takes the address from `spValue` instead of `rdDataB`. If `spValue[3:0]` is not zero, `alignFault` pulses for one cycle and there is neither a memory access nor a writeback. No alignment check applies to other base registers.
- R7: A destination field of 31 produces no `wbValid` pulse. The memory update still takes place.
- R8: An operand field of 31 supplies zero as the XOR operand, whatever `rdDataA` returns, so memory is rewritten unchanged.
- R9: `memLock` is high without a break from the cycle the read request is presented until the write request is accepted.
- R10: Out of reset, `busy` is low and `instReady` is high. `busy` is high from the cycle after acceptance through the writeback cycle, or until write acceptance when R7 applies. `instReady` is the inverse of `busy`.
- R11: While a request waits with `memReqReady` low, `memReqValid`, `memReqWrite`, `memAddr` and `memWdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction word offered |
| instWord | input | 32 | Instruction word |
| instReady | output | 1 | Unit idle, instruction taken this cycle if offered |
| rdAddrA | output | 5 | Operand register number |
| rdDataA | input | 64 | Operand register value |
| rdAddrB | output | 5 | Base register number |
| rdDataB | input | 64 | Base register value |
| spValue | input | 64 | Stack-pointer value |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | 64 | Memory byte address |
| memWdata | output | 64 | Write data |
| memWstrb | output | 8 | Byte write enables |
| memLock | output | 1 | Location locked for the read-modify-write |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Read data |
| wbValid | output | 1 | Destination register write |
| wbAddr | output | 5 | Destination register number |
| wbData | output | 64 | Value loaded from memory |
| busy | output | 1 | Instruction in progress |
| illegal | output | 1 | One-cycle pulse for a non-matching word |
| alignFault | output | 1 | One-cycle pulse for a misaligned stack pointer |

## Verification
The hardest case to reach is a misaligned stack pointer. It fires only when the base field is 31, and every one of the fifteen nonzero low nibbles must abort before any memory request. The bench sweeps those nibbles with base 31, and repeats them with an ordinary base register to show that no check applies there. A second hard case is a lock that must hold across stalls. Half of the sweep runs with the memory ready toggling, so the lock, the address and the write data are observed while requests wait.

// File: rtl/axu_pkg.sv
package axu_pkg;
  localparam int INST_W = 32;
  localparam int DATA_W = 64;
  localparam int REG_AW = 5;
  localparam int STRB_W = DATA_W / 8;
  localparam logic [INST_W-1:0] OP_MASK  = 32'hBFE0_FC00;
  localparam logic [INST_W-1:0] OP_MATCH = 32'hB820_2000;
  localparam logic [REG_AW-1:0] ZR_IDX   = 5'd31;

  typedef struct packed {
    logic latchInst;
    logic captureOps;
    logic captureOld;
  } dpCtrl_t;

  typedef struct packed {
    logic match;
    logic is64;
    logic rtIsZr;
    logic alignBad;
  } dpStat_t;
endpackage

// File: rtl/axu_dp.sv
module axu_dp
  import axu_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [INST_W-1:0] instWord,
  output dpStat_t           stat,
  output logic [REG_AW-1:0] rdAddrA,
  input  logic [DATA_W-1:0] rdDataA,
  output logic [REG_AW-1:0] rdAddrB,
  input  logic [DATA_W-1:0] rdDataB,
  input  logic [ADDR_W-1:0] spValue,
  input  logic [DATA_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [STRB_W-1:0] memWstrb,
  output logic [REG_AW-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [STRB_W-1:0] WORD_STRB = {{(STRB_W/2){1'b0}}, {(STRB_W/2){1'b1}}};

  logic [INST_W-1:0] instQ;
  logic [DATA_W-1:0] rsVal;
  logic [DATA_W-1:0] oldVal;
  logic [ADDR_W-1:0] baseAddr;
  logic [REG_AW-1:0] rsF, rnF, rtF;
  logic              is64;
  logic [DATA_W-1:0] rsSrc;

  assign rsF  = instQ[20:16];
  assign rnF  = instQ[9:5];
  assign rtF  = instQ[4:0];
  assign is64 = instQ[30];

  assign stat.match    = (instWord & OP_MASK) == OP_MATCH;
  assign stat.is64     = is64;
  assign stat.rtIsZr   = (rtF == ZR_IDX);
  assign stat.alignBad = (rnF == ZR_IDX) && (spValue[ALIGN_BITS-1:0] != '0);

  assign rsSrc = (rsF == ZR_IDX) ? '0 : rdDataA;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instQ    <= '0;
      rsVal    <= '0;
      oldVal   <= '0;
      baseAddr <= '0;
    end else begin
      if (ctl.latchInst) instQ <= instWord;
      if (ctl.captureOps) begin
        rsVal    <= is64 ? rsSrc : {{HALF_W{1'b0}}, rsSrc[HALF_W-1:0]};
        baseAddr <= (rnF == ZR_IDX) ? spValue : rdDataB[ADDR_W-1:0];
      end
      if (ctl.captureOld)
        oldVal <= is64 ? memRspData : {{HALF_W{1'b0}}, memRspData[HALF_W-1:0]};
    end
  end

  assign rdAddrA  = rsF;
  assign rdAddrB  = rnF;
  assign memAddr  = baseAddr;
  assign memWdata = oldVal ^ rsVal;
  assign memWstrb = is64 ? '1 : WORD_STRB;
  assign wbAddr   = rtF;
  assign wbData   = oldVal;

  // R4: a word access never carries data above the low half
  assert_word_upper_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureOld && !is64 |=> memWdata[DATA_W-1:HALF_W] == '0);
endmodule

// File: rtl/axu_ctrl.sv
module axu_ctrl
  import axu_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    instValid,
  input  dpStat_t stat,
  input  logic    memReqReady,
  input  logic    memRspValid,
  output dpCtrl_t ctl,
  output logic    instReady,
  output logic    busy,
  output logic    memReqValid,
  output logic    memReqWrite,
  output logic    memLock,
  output logic    wbValid,
  output logic    illegal,
  output logic    alignFault
);
  typedef enum logic [2:0] {
    S_IDLE, S_OPS, S_RDREQ, S_RDRSP, S_WRREQ, S_WB
  } state_t;

  state_t state, stateNxt;
  logic   accept;
  logic   illegalQ, faultQ;

  assign accept = instValid && (state == S_IDLE);

  always_comb begin
    stateNxt       = state;
    ctl.latchInst  = 1'b0;
    ctl.captureOps = 1'b0;
    ctl.captureOld = 1'b0;
    unique case (state)
      S_IDLE: if (accept && stat.match) begin
        ctl.latchInst = 1'b1;
        stateNxt      = S_OPS;
      end
      S_OPS: begin
        ctl.captureOps = 1'b1;
        stateNxt       = stat.alignBad ? S_IDLE : S_RDREQ;
      end
      S_RDREQ: if (memReqReady) stateNxt = S_RDRSP;
      S_RDRSP: if (memRspValid) begin
        ctl.captureOld = 1'b1;
        stateNxt       = S_WRREQ;
      end
      S_WRREQ: if (memReqReady) stateNxt = stat.rtIsZr ? S_IDLE : S_WB;
      S_WB:    stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      illegalQ <= 1'b0;
      faultQ   <= 1'b0;
    end else begin
      state    <= stateNxt;
      illegalQ <= accept && !stat.match;
      faultQ   <= (state == S_OPS) && stat.alignBad;
    end
  end

  assign instReady   = (state == S_IDLE);
  assign busy        = (state != S_IDLE);
  assign memReqValid = (state == S_RDREQ) || (state == S_WRREQ);
  assign memReqWrite = (state == S_WRREQ);
  assign memLock     = (state == S_RDREQ) || (state == S_RDRSP) || (state == S_WRREQ);
  assign wbValid     = (state == S_WB);
  assign illegal     = illegalQ;
  assign alignFault  = faultQ;

  assert_illegal_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !busy && !memLock);

  assert_lock_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    memLock && !(memReqValid && memReqWrite && memReqReady) |=> memLock);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqWrite));

  assert_fault_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> !memReqValid && !wbValid && !busy);

  assert_wb_after_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(memReqValid && memReqWrite && memReqReady));
endmodule

// File: rtl/atomic_xor_unit.sv
module atomic_xor_unit
  import axu_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  output logic              instReady,
  output logic [4:0]        rdAddrA,
  input  logic [63:0]       rdDataA,
  output logic [4:0]        rdAddrB,
  input  logic [63:0]       rdDataB,
  input  logic [ADDR_W-1:0] spValue,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  output logic [7:0]        memWstrb,
  output logic              memLock,
  input  logic              memRspValid,
  input  logic [63:0]       memRspData,
  output logic              wbValid,
  output logic [4:0]        wbAddr,
  output logic [63:0]       wbData,
  output logic              busy,
  output logic              illegal,
  output logic              alignFault
);
  dpCtrl_t ctl;
  dpStat_t stat;

  axu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .stat(stat),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .ctl(ctl),
    .instReady(instReady), .busy(busy), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .memLock(memLock), .wbValid(wbValid),
    .illegal(illegal), .alignFault(alignFault)
  );

  axu_dp #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .instWord(instWord), .stat(stat),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .spValue(spValue), .memRspData(memRspData), .memAddr(memAddr),
    .memWdata(memWdata), .memWstrb(memWstrb), .wbAddr(wbAddr), .wbData(wbData)
  );

  assert_wb_zero_ext_R5: assert property (@(posedge clk) disable iff (!rstN)
    wbValid && !stat.is64 |-> wbData[63:32] == '0);

  assert_wb_not_zr_R7: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> wbAddr != ZR_IDX);

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memAddr) && $stable(memWdata));

  assert_busy_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy != instReady);
endmodule

// File: tb/atomic_xor_unit_test.sv
module atomic_xor_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        instReady;
  logic [4:0]  rdAddrA, rdAddrB, wbAddr;
  logic [63:0] rdDataA, rdDataB, spValue, memAddr, memWdata, memRspData, wbData;
  logic        memReqValid, memReqReady, memReqWrite, memLock, memRspValid;
  logic [7:0]  memWstrb;
  logic        wbValid, busy, illegal, alignFault;

  always #2 clk = ~clk;

  logic [63:0] regs [32];
  logic [63:0] memArr [16];
  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  atomic_xor_unit uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instWord(instWord),
    .instReady(instReady), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .spValue(spValue),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memWstrb(memWstrb), .memLock(memLock), .memRspValid(memRspValid),
    .memRspData(memRspData), .wbValid(wbValid), .wbAddr(wbAddr),
    .wbData(wbData), .busy(busy), .illegal(illegal), .alignFault(alignFault)
  );

  int total = 0, bad = 0;
  int reads, writes, wbSeen, faultSeen, illegalSeen, lockBad, busyBad, holdBad;
  logic [63:0] rdAddrSeen, wrAddrSeen, wbDataSeen;
  logic [4:0]  wbAddrSeen;
  logic [7:0]  strbSeen;
  logic        rspPend = 1'b0, stallMode = 1'b0, prevWb = 1'b0, prevStall = 1'b0;
  logic [3:0]  rdIdx = '0;
  logic [63:0] prevAddr, prevData;
  int          tick = 0, cyc = 0;
  bit          finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mix(input int k);
    return (64'h9E37_79B9_7F4A_7C15 * 64'(k + 1)) ^ 64'hD1B5_4A32_D192_ED03;
  endfunction

  // memory and monitor model, all at the falling edge
  always @(negedge clk) begin
    if (rspPend) begin
      memRspValid = 1'b1; memRspData = memArr[rdIdx]; rspPend = 1'b0;
    end else memRspValid = 1'b0;
    tick++;
    memReqReady = stallMode ? (tick[0] ^ tick[2]) : 1'b1;
    if (prevStall && (memAddr != prevAddr || memWdata != prevData || !memReqValid)) holdBad++;
    prevStall = memReqValid && !memReqReady;
    prevAddr = memAddr; prevData = memWdata;
    if (memReqValid && memReqReady) begin
      if (!memLock) lockBad++;
      if (memReqWrite) begin
        for (int b = 0; b < 8; b++)
          if (memWstrb[b]) memArr[memAddr[6:3]][b*8 +: 8] = memWdata[b*8 +: 8];
        writes++; wrAddrSeen = memAddr; strbSeen = memWstrb;
      end else begin
        rspPend = 1'b1; rdIdx = memAddr[6:3]; reads++; rdAddrSeen = memAddr;
      end
    end
    if (prevWb && busy) busyBad++;
    prevWb = wbValid;
    if (wbValid) begin wbSeen++; wbAddrSeen = wbAddr; wbDataSeen = wbData; end
    if (alignFault) faultSeen++;
    if (illegal) illegalSeen++;
  end

  task automatic clearCounts();
    reads = 0; writes = 0; wbSeen = 0; faultSeen = 0; illegalSeen = 0;
    lockBad = 0; busyBad = 0; holdBad = 0;
  endtask

  task automatic issue(input logic [31:0] w);
    int n;
    @(negedge clk);
    chk(instReady, "R10 ready before issue", 64'(instReady), 64'd1);
    instValid = 1'b1; instWord = w;
    @(negedge clk);
    instValid = 1'b0;
    n = 0;
    while (busy && n < 300) begin @(negedge clk); n++; end
    chk(n < 300, "R10 op completes", 64'(n), 64'd0);
    @(negedge clk);
  endtask

  function automatic logic [31:0] enc(input bit d, input logic [4:0] rs, input logic [4:0] rn, input logic [4:0] rt);
    return {1'b1, d, 3'b111, 1'b0, 2'b00, 2'b00, 1'b1, rs, 1'b0, 3'b010, 2'b00, rn, rt};
  endfunction

  task automatic legalOp(input bit d, input logic [4:0] rs, input logic [4:0] rn, input logic [4:0] rt);
    logic [63:0] base, old, rsv, expMem, expWb;
    base = (rn == 5'd31) ? spValue : regs[rn];
    old  = memArr[base[6:3]];
    rsv  = (rs == 5'd31) ? 64'd0 : regs[rs];
    if (d) begin expMem = old ^ rsv; expWb = old; end
    else begin
      expMem = {old[63:32], old[31:0] ^ rsv[31:0]};
      expWb  = {32'd0, old[31:0]};
    end
    clearCounts();
    issue(enc(d, rs, rn, rt));
    chk(reads == 1 && writes == 1, "R3 one read one write", 64'(reads * 16 + writes), 64'h11);
    chk(rdAddrSeen == base && wrAddrSeen == base, (rn == 5'd31) ? "R6 sp base address" : "R2 R3 base address", wrAddrSeen, base);
    chk(memArr[base[6:3]] == expMem, (rs == 5'd31) ? "R8 zero operand" : "R3 R4 memory result", memArr[base[6:3]], expMem);
    chk(strbSeen == (d ? 8'hFF : 8'h0F), "R4 strobe", 64'(strbSeen), d ? 64'hFF : 64'h0F);
    chk(lockBad == 0 && holdBad == 0, "R9 R11 lock and hold", 64'(lockBad + holdBad), 64'd0);
    chk(busyBad == 0 && faultSeen == 0 && illegalSeen == 0, "R10 busy end", 64'(busyBad), 64'd0);
    if (rt == 5'd31) chk(wbSeen == 0, "R7 no writeback", 64'(wbSeen), 64'd0);
    else begin
      chk(wbSeen == 1 && wbAddrSeen == rt, "R2 writeback register", 64'(wbAddrSeen), 64'(rt));
      chk(wbDataSeen == expWb, d ? "R3 returned value" : "R5 zero extended", wbDataSeen, expWb);
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = mix(i);
    regs[2] = 64'h28; regs[7] = 64'h50;
    for (int i = 0; i < 16; i++) memArr[i] = mix(i + 100);
    spValue = 64'h60;
    memRspData = '0; memRspValid = 1'b0; memReqReady = 1'b1;
    clearCounts();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && instReady, "R10 reset busy/ready", 64'(busy), 64'd0);
    chk(!memReqValid && !memLock && !wbValid && !illegal && !alignFault, "R10 reset outputs",
        64'({memReqValid, memLock, wbValid, illegal, alignFault}), 64'd0);

    // near-exhaustive legal sweep: size x operand x base x dest x stall
    for (int st = 0; st < 2; st++) begin
      stallMode = st[0];
      for (int d = 0; d < 2; d++)
        foreach (regs[rsI]) if (rsI == 4 || rsI == 2 || rsI == 31)
          for (int rn = 0; rn < 3; rn++)
            for (int rt = 0; rt < 3; rt++)
              legalOp(d[0], 5'(rsI), (rn == 0) ? 5'd2 : (rn == 1) ? 5'd7 : 5'd31,
                      (rt == 0) ? 5'd3 : (rt == 1) ? 5'd31 : 5'd0);
    end
    stallMode = 1'b0;

    // R6 misaligned stack pointer: every nonzero low nibble
    for (int nib = 1; nib < 16; nib++) begin
      spValue = 64'h40 | 64'(nib);
      clearCounts();
      issue(enc(nib[0], 5'd4, 5'd31, 5'd3));
      chk(faultSeen == 1, "R6 fault pulse", 64'(faultSeen), 64'd1);
      chk(reads == 0 && writes == 0 && wbSeen == 0, "R6 no access on fault",
          64'(reads + writes + wbSeen), 64'd0);
      // a general base register is never alignment checked
      legalOp(nib[1], 5'd4, 5'd2, 5'd5);
    end
    spValue = 64'h60;

    // R1 illegal: flip each fixed bit of a valid word
    for (int b = 0; b < 32; b++) begin
      if (b == 30 || (b >= 16 && b <= 20) || b < 10) continue;
      clearCounts();
      issue(enc(1'b1, 5'd4, 5'd7, 5'd3) ^ (32'd1 << b));
      chk(illegalSeen == 1, "R1 illegal pulse", 64'(illegalSeen), 64'd1);
      chk(reads == 0 && writes == 0 && wbSeen == 0, "R1 no access",
          64'(reads + writes + wbSeen), 64'd0);
    end
    // R1 bit 30 is the size bit, both values legal
    legalOp(1'b0, 5'd6, 5'd7, 5'd8);
    legalOp(1'b1, 5'd6, 5'd7, 5'd8);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule